// File: doc/BRIEF.md
# Half-Step Fractional Pixel Clock Divider

This block derives a pixel clock from a fast display source clock. The ratio comes from an 8-bit code in 7.1 fixed point, where the lowest bit is worth one half. The code is stored with an offset of two half-steps, so the period of the output is `code + 2` source half-periods. Code 0 passes the source rate through (divide by 1), code 1 divides by 1.5, code 3 divides by 2.5, and so on up to divide by 128.5.

The block runs on `clk_half`, a clock with one edge for every half-period of the source clock. The block therefore works as a clock-enable generator at twice the source resolution. It drives a registered `pix_clk` waveform. It also drives `pix_en`, a one-cycle pulse that opens each output period, and `ratio_valid`, which shows that the waveform matches the code currently on the input.

A small state machine controls the waveform:
- **START** is held during reset. Its only transition is *launch* to HIGH, taken on the first edge after reset is released, and it loads the code at that edge.
- **HIGH** drives `pix_clk` high. It takes *hold_high* while its phase is not finished and *fall* to LOW when the phase ends.
- **LOW** drives `pix_clk` low. It takes *hold_low* while its phase is not finished and *wrap* back to HIGH when the phase ends. On *wrap* it samples the next code and updates the valid flag.

Top module: `halfstep_clkdiv`

## Requirements
- R1: While `rst_n` is low, `pix_clk`, `pix_en` and `ratio_valid` are all 0.
- R2: With a steady code `c`, the `pix_clk` period is exactly `c + 2` cycles of `clk_half`. Code 0 therefore gives a period of 2 cycles.
- R3: The high phase lasts `ceil((c+2)/2)` cycles and the low phase lasts `floor((c+2)/2)` cycles. The two phases are equal for an even count, and the high phase is one cycle longer for an odd count.
- R4: `pix_en` is high for exactly one cycle per period, in the first cycle of each high phase, and never while `pix_clk` is low.
- R5: The code is sampled only at a period boundary. A code change in the middle of a period leaves the lengths of that period's high and low phases unchanged.
- R6: When the code sampled at a boundary differs from the code in use, `ratio_valid` goes to 0 at that boundary.
- R7: `ratio_valid` goes to 1 at the end of the first complete period that follows reset or a code change, provided the input code has not changed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_half | input | 1 | Clock with one edge per source half-period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 8 | Divider code in 7.1 format, with an offset of 2 half-steps |
| pix_clk | output | 1 | Divided pixel clock waveform, registered |
| pix_en | output | 1 | One-cycle pulse at the start of each output period |
| ratio_valid | output | 1 | The output waveform matches the input code |

## Verification
Every output is registered. `pix_clk`, `pix_en` and `ratio_valid` all change on the same `clk_half` edge that begins a period, so the boundary shows in the cycle right after the edge where `wrap` or `launch` is taken. The bench samples at the falling edge and finds each period start by seeing `pix_clk` go from low to high. At that start it reads `pix_en` and `ratio_valid`, then counts high and low cycles up to the next start. After a code change, the first boundary must show the valid flag cleared and the second boundary must show it set, and only the period that follows is measured against the new code.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_HIGH  = 2'd1,
        ST_LOW   = 2'd2
    } hsd_state_e;
endpackage

// File: rtl/hsd_len_calc.sv
// Turns a 7.1 offset code into the lengths of the high and low phases,
// counted in half-steps.
module hsd_len_calc #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] hi_len,
    output logic [CODE_W-1:0] lo_len
);
    localparam int NW = CODE_W + 1;

    logic [NW-1:0] n_half;
    logic [NW-1:0] hi_full;
    logic [NW-1:0] lo_full;

    always_comb begin
        n_half  = {1'b0, code} + NW'(2);
        hi_full = (n_half + NW'(1)) >> 1;
        lo_full = n_half >> 1;
        hi_len  = hi_full[CODE_W-1:0];
        lo_len  = lo_full[CODE_W-1:0];
    end
endmodule

// File: rtl/hsd_phase_fsm.sv
module hsd_phase_fsm
    import hsd_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic [CODE_W-1:0] hi_len,
    input  logic [CODE_W-1:0] lo_len,
    output logic [CODE_W-1:0] cur_code,
    output logic              pix_clk_q,
    output logic              pix_en_q,
    output logic              valid_q
);
    hsd_state_e        state, nxt;
    logic [CODE_W-1:0] cnt;
    logic              end_hi, end_lo;

    assign end_hi = (cnt == hi_len - CODE_W'(1));
    assign end_lo = (cnt == lo_len - CODE_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_START;
        else        state <= nxt;
    end

    // transitions: launch, hold_high, fall, hold_low, wrap
    always_comb begin
        nxt = state;
        unique case (state)
            ST_START: nxt = ST_HIGH;
            ST_HIGH:  nxt = end_hi ? ST_LOW : ST_HIGH;
            ST_LOW:   nxt = end_lo ? ST_HIGH : ST_LOW;
            default:  nxt = ST_START;
        endcase
    end

    // phase counter, code capture, valid tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            cur_code <= '0;
            valid_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_START: begin
                    cnt      <= '0;
                    cur_code <= code_in;
                end
                ST_HIGH: cnt <= end_hi ? '0 : cnt + CODE_W'(1);
                ST_LOW: begin
                    if (end_lo) begin
                        cnt      <= '0;
                        cur_code <= code_in;
                        valid_q  <= (code_in == cur_code);
                    end else begin
                        cnt <= cnt + CODE_W'(1);
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_clk_q <= 1'b0;
            pix_en_q  <= 1'b0;
        end else begin
            pix_clk_q <= (nxt == ST_HIGH);
            pix_en_q  <= (nxt == ST_HIGH) && (state != ST_HIGH);
        end
    end

    // R4
    en_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en_q |-> pix_clk_q);

    // R4
    en_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en_q |=> !pix_en_q);

    // R5
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en_q |-> $stable(cur_code));

    // R6 R7
    valid_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(valid_q) || $fell(valid_q)) |-> pix_en_q);
endmodule

// File: rtl/halfstep_clkdiv.sv
module halfstep_clkdiv #(
    parameter int CODE_W = 8
) (
    input  logic              clk_half,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_code,
    output logic              pix_clk,
    output logic              pix_en,
    output logic              ratio_valid
);
    logic [CODE_W-1:0] cur_code;
    logic [CODE_W-1:0] hi_len;
    logic [CODE_W-1:0] lo_len;

    hsd_len_calc #(.CODE_W(CODE_W)) u_len (
        .code   (cur_code),
        .hi_len (hi_len),
        .lo_len (lo_len)
    );

    hsd_phase_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk       (clk_half),
        .rst_n     (rst_n),
        .code_in   (ratio_code),
        .hi_len    (hi_len),
        .lo_len    (lo_len),
        .cur_code  (cur_code),
        .pix_clk_q (pix_clk),
        .pix_en_q  (pix_en),
        .valid_q   (ratio_valid)
    );
endmodule

// File: tb/tb_halfstep_clkdiv.sv
`timescale 1ns/1ps
module tb_halfstep_clkdiv;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] code = 8'd0;
    logic       pix_clk, pix_en, ratio_valid;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    halfstep_clkdiv dut (
        .clk_half    (clk),
        .rst_n       (rst_n),
        .ratio_code  (code),
        .pix_clk     (pix_clk),
        .pix_en      (pix_en),
        .ratio_valid (ratio_valid)
    );

    typedef struct packed {
        logic [7:0] c;
        logic [7:0] hi;
        logic [7:0] lo;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{8'd0,   8'd1,   8'd1},
        '{8'd1,   8'd2,   8'd1},
        '{8'd2,   8'd2,   8'd2},
        '{8'd3,   8'd3,   8'd2},
        '{8'd7,   8'd5,   8'd4},
        '{8'd128, 8'd65,  8'd65},
        '{8'd254, 8'd128, 8'd128},
        '{8'd255, 8'd129, 8'd128}
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // returns at the falling edge inside the first high cycle of a period
    task automatic wait_rise();
        do @(negedge clk); while (pix_clk !== 1'b0);
        do @(negedge clk); while (pix_clk !== 1'b1);
    endtask

    // call at the first high cycle; returns at the next one
    task automatic measure(output int hi, output int lo, output int ens);
        hi = 0; lo = 0; ens = 0;
        while (pix_clk === 1'b1) begin
            hi++; if (pix_en) ens++;
            @(negedge clk);
        end
        while (pix_clk === 1'b0) begin
            lo++; if (pix_en) ens++;
            @(negedge clk);
        end
    endtask

    task automatic run_code(input int c, input int ehi, input int elo);
        int hi, lo, ens;
        code = 8'(c);
        wait_rise();
        check("R6 valid cleared", int'(ratio_valid), 0);
        wait_rise();
        check("R7 valid set", int'(ratio_valid), 1);
        check("R4 en at rise", int'(pix_en), 1);
        measure(hi, lo, ens);
        check("R2 period", hi + lo, c + 2);
        check("R3 high phase", hi, ehi);
        check("R3 low phase", lo, elo);
        check("R4 one en per period", ens, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pix_clk", int'(pix_clk), 0);
        check("R1 pix_en", int'(pix_en), 0);
        check("R1 valid", int'(ratio_valid), 0);
        code = 8'd5;
        rst_n = 1'b1;
        begin
            int hi, lo, ens;
            wait_rise();
            wait_rise();
            check("R7 valid after reset", int'(ratio_valid), 1);
            measure(hi, lo, ens);
            check("R2 period after reset", hi + lo, 7);
        end
        for (int i = 0; i < 8; i++)
            run_code(int'(TBL[i].c), int'(TBL[i].hi), int'(TBL[i].lo));
        for (int c = 0; c < 256; c++)
            run_code(c, (c + 3) / 2, (c + 2) / 2);
        // R5 mid-period change keeps the running period intact
        begin
            int hi, lo, ens;
            run_code(10, 6, 6);
            code = 8'd40;
            measure(hi, lo, ens);
            check("R5 old high kept", hi, 6);
            check("R5 old low kept", lo, 6);
            check("R6 cleared at boundary", int'(ratio_valid), 0);
            measure(hi, lo, ens);
            check("R5 new period", hi + lo, 42);
            check("R7 set after full period", int'(ratio_valid), 1);
        end
        // R1 reset in the middle of running
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pix_clk mid reset", int'(pix_clk), 0);
        check("R1 pix_en mid reset", int'(pix_en), 0);
        check("R1 valid mid reset", int'(ratio_valid), 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule